// File: doc/BRIEF.md
# Bus-Mastering DMA Channel Control Registers

This block is the host-facing register front of one bus-mastering disk DMA channel. Software programs a descriptor table base, then arms the channel by setting a start bit. The block tells the attached DMA engine when to reload its working descriptor pointer and when to begin moving data. A set-up change of direction bit steers the engine. When software drops the start bit, the block does not cut off a transfer that is in progress: it holds the channel active until the engine reports it is idle.

The block also sits in the drive's interrupt path. The drive interrupt level goes straight to the interrupt output, and each rising edge latches a sticky status flag that software clears by writing a one to it. The engine reports the end of a transfer and says whether the channel should stay active.

Writes come as 1, 2 or 4 byte accesses with a byte offset. Reads are combinational and return the addressed byte lanes, zero-extended.

Top module: `busdma_ctl_regs`

## Requirements
- R1: The command register (select 0) keeps only bit 0 (start) and bit 3 (direction) of the written byte. All other bits read back as zero. `eng_dir` shows bit 3.
- R2: A command write whose bit 0 equals the stored start bit updates the stored bits only. It raises neither `eng_reload` nor `eng_kick`.
- R3: A command write that moves start from 0 to 1 raises `eng_reload` for one cycle after the write edge and copies the table pointer to `eng_ptr`. If the channel was inactive, the same write also sets active (status bit 0, `eng_active`) and raises `eng_kick` for that one cycle.
- R4: A command write that moves start from 1 to 0 clears active at the write edge if `eng_busy` is low. If `eng_busy` is high, active stays set until the first clock edge at which `eng_busy` is low.
- R5: The table pointer (select 2) takes byte writes at offsets 0–3, halfword writes at offsets 0–2 and word writes at offset 0. Only the addressed lanes change (size code 0 byte, 1 halfword, 2 word). Bits 1:0 always hold zero.
- R6: `irq_out` equals `drv_irq` combinationally. A rising edge of `drv_irq` sets status bit 2 at the next clock edge.
- R7: In the status register (select 1), writing 1 to bit 2 clears it, unless a new rising edge arrives in the same cycle, in which case the set wins. Bits 6:5 are plain read/write. Bit 0 ignores writes, and all other bits read as zero.
- R8: While active after a start, an `eng_done` pulse with `eng_more` high keeps active set. With `eng_more` low it clears active.
- R9: A read returns the selected register shifted right by 8×offset and masked to the access size. Select 3 reads zero.
- R10: Synchronous reset clears the command, the status, the table pointer and `eng_ptr`, and leaves the channel inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Register write strobe |
| acc_sel | input | 2 | Write register select (0 cmd, 1 status, 2 table pointer) |
| acc_off | input | 2 | Write byte offset |
| acc_size | input | 2 | Write size (0 byte, 1 half, 2 word) |
| acc_wdata | input | 32 | Write data, low-justified |
| rd_sel | input | 2 | Read register select |
| rd_off | input | 2 | Read byte offset |
| rd_size | input | 2 | Read size |
| rd_data | output | 32 | Read data, zero-extended |
| eng_busy | input | 1 | Engine has a transfer in flight |
| eng_done | input | 1 | Engine finished a transfer |
| eng_more | input | 1 | With eng_done: keep channel active |
| eng_kick | output | 1 | One-cycle start trigger to engine |
| eng_reload | output | 1 | One-cycle descriptor pointer reload |
| eng_active | output | 1 | Channel active |
| eng_dir | output | 1 | Transfer direction |
| eng_ptr | output | 32 | Current descriptor pointer |
| drv_irq | input | 1 | Drive interrupt level |
| irq_out | output | 1 | Interrupt to host |

## Verification
The assertions assume at most one register write per cycle. They also assume that `eng_done` is pulsed only while the channel is active, and that halfword and word accesses never cross the 4-byte boundary. The bench issues writes one at a time, each with the strobe high for exactly one clock. It uses only offset/size pairs that fit inside the register and pulses `eng_done` only after a start has made the channel active. The stop-while-busy path is covered by holding `eng_busy` high across several edges before releasing it.

// File: rtl/dctl_pkg.sv
package dctl_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        REG_CMD  = 2'd0,
        REG_STS  = 2'd1,
        REG_TBL  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RUN_IDLE  = 2'd0,
        RUN_ON    = 2'd1,
        RUN_DRAIN = 2'd2
    } run_state_e;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_DIR_BIT   = 3;
    localparam int STS_ACT_BIT   = 0;
    localparam int STS_IRQ_BIT   = 2;
    localparam logic [7:0] CMD_KEEP = 8'h09;

    typedef struct packed {
        logic                en;
        reg_sel_e            sel;
        logic [1:0]          off;
        acc_size_e           size;
        logic [DATA_W-1:0]   data;
    } host_wr_t;

    function automatic logic [LANES-1:0] lane_mask(acc_size_e sz, logic [1:0] off);
        case (sz)
            SZ_BYTE: return LANES'(4'b0001 << off);
            SZ_HALF: return LANES'(4'b0011 << off);
            default: return {LANES{1'b1}};
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lane_place(acc_size_e sz, logic [1:0] off,
                                                     logic [DATA_W-1:0] d);
        if (sz == SZ_WORD || sz == SZ_RSVD) return d;
        return d << {off, 3'b000};
    endfunction

    function automatic logic [DATA_W-1:0] lane_pick(acc_size_e sz, logic [1:0] off,
                                                    logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] s;
        s = v >> {off, 3'b000};
        case (sz)
            SZ_BYTE: return {{(DATA_W-8){1'b0}}, s[7:0]};
            SZ_HALF: return {{(DATA_W-16){1'b0}}, s[15:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/dctl_tbl_ptr.sv
module dctl_tbl_ptr
    import dctl_pkg::*;
#(
    parameter int PTR_W = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  host_wr_t         wr,
    output logic [PTR_W-1:0] tbl_ptr
);
    localparam int PLANES = PTR_W / 8;

    logic             hit;
    logic [PLANES-1:0] mask;
    logic [PTR_W-1:0] placed;
    logic [PTR_W-1:0] ptr_q;

    assign hit    = wr.en && (wr.sel == REG_TBL);
    assign mask   = PLANES'(lane_mask(wr.size, wr.off));
    assign placed = PTR_W'(lane_place(wr.size, wr.off, wr.data));

    for (genvar i = 0; i < PLANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[i*8 +: 8] <= '0;
            end else if (hit && mask[i]) begin
                if (i == 0)
                    ptr_q[i*8 +: 8] <= placed[i*8 +: 8] & ~8'((1 << ALIGN_BITS) - 1);
                else
                    ptr_q[i*8 +: 8] <= placed[i*8 +: 8];
            end
        end
    end

    assign tbl_ptr = ptr_q;

endmodule

// File: rtl/dctl_run_ctl.sv
module dctl_run_ctl
    import dctl_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  host_wr_t         wr,
    input  logic [PTR_W-1:0] tbl_ptr,
    input  logic             eng_busy,
    input  logic             eng_done,
    input  logic             eng_more,
    output logic [7:0]       cmd_q,
    output logic             active,
    output logic             kick,
    output logic             reload,
    output logic [PTR_W-1:0] cur_ptr
);
    run_state_e state_q, state_n;
    logic       cmd_wr, go, halt;
    logic       kick_n, reload_n;

    assign cmd_wr = wr.en && (wr.sel == REG_CMD);
    assign go     = cmd_wr &&  wr.data[CMD_START_BIT] && !cmd_q[CMD_START_BIT];
    assign halt   = cmd_wr && !wr.data[CMD_START_BIT] &&  cmd_q[CMD_START_BIT];

    always_comb begin
        state_n  = state_q;
        kick_n   = 1'b0;
        reload_n = 1'b0;
        if (go) begin
            state_n  = RUN_ON;
            reload_n = 1'b1;
            kick_n   = (state_q == RUN_IDLE);
        end else if (halt) begin
            state_n = (state_q != RUN_IDLE && eng_busy) ? RUN_DRAIN : RUN_IDLE;
        end else begin
            case (state_q)
                RUN_DRAIN: if (!eng_busy) state_n = RUN_IDLE;
                RUN_ON:    if (eng_done && !eng_more) state_n = RUN_IDLE;
                default:   state_n = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RUN_IDLE;
            kick    <= 1'b0;
            reload  <= 1'b0;
            cmd_q   <= '0;
            cur_ptr <= '0;
        end else begin
            state_q <= state_n;
            kick    <= kick_n;
            reload  <= reload_n;
            if (cmd_wr)   cmd_q   <= wr.data[7:0] & CMD_KEEP;
            if (reload_n) cur_ptr <= tbl_ptr;
        end
    end

    assign active = (state_q != RUN_IDLE);

    AST_KICK_ACTIVATES: assert property (@(posedge clk) disable iff (rst)
        kick |-> (active && !$past(active))); // R3
    AST_SAME_START_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && (wr.data[CMD_START_BIT] == cmd_q[CMD_START_BIT])) |=> (!kick && !reload)); // R2
    AST_STOP_WAITS: assert property (@(posedge clk) disable iff (rst)
        (halt && eng_busy && active) |=> active); // R4

endmodule

// File: rtl/dctl_status.sv
module dctl_status
    import dctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  host_wr_t wr,
    input  logic     active,
    input  logic     drv_irq,
    output logic [7:0] sts_byte,
    output logic     irq_out
);
    logic       drv_q, irq_flag;
    logic [1:0] misc_q;
    logic       sts_wr, rise;

    assign sts_wr = wr.en && (wr.sel == REG_STS);
    assign rise   = drv_irq && !drv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q    <= 1'b0;
            irq_flag <= 1'b0;
            misc_q   <= '0;
        end else begin
            drv_q <= drv_irq;
            if (rise)
                irq_flag <= 1'b1;
            else if (sts_wr && wr.data[STS_IRQ_BIT])
                irq_flag <= 1'b0;
            if (sts_wr) misc_q <= wr.data[6:5];
        end
    end

    assign sts_byte = {1'b0, misc_q, 2'b00, irq_flag, 1'b0, active};
    assign irq_out  = drv_irq;

    AST_IRQ_LATCHED: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_irq) |=> sts_byte[STS_IRQ_BIT]); // R6

endmodule

// File: rtl/busdma_ctl_regs.sv
module busdma_ctl_regs
    import dctl_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_en,
    input  logic [1:0]  acc_sel,
    input  logic [1:0]  acc_off,
    input  logic [1:0]  acc_size,
    input  logic [31:0] acc_wdata,
    input  logic [1:0]  rd_sel,
    input  logic [1:0]  rd_off,
    input  logic [1:0]  rd_size,
    output logic [31:0] rd_data,
    input  logic        eng_busy,
    input  logic        eng_done,
    input  logic        eng_more,
    output logic        eng_kick,
    output logic        eng_reload,
    output logic        eng_active,
    output logic        eng_dir,
    output logic [31:0] eng_ptr,
    input  logic        drv_irq,
    output logic        irq_out
);
    host_wr_t         wr;
    logic [PTR_W-1:0] tbl_ptr, cur_ptr;
    logic [7:0]       cmd_q, sts_byte;
    logic             active;
    logic [31:0]      rd_raw;

    assign wr = '{en: acc_en, sel: reg_sel_e'(acc_sel), off: acc_off,
                  size: acc_size_e'(acc_size), data: acc_wdata};

    dctl_tbl_ptr #(.PTR_W(PTR_W)) u_tbl (
        .clk(clk), .rst(rst), .wr(wr), .tbl_ptr(tbl_ptr)
    );

    dctl_run_ctl #(.PTR_W(PTR_W)) u_run (
        .clk(clk), .rst(rst), .wr(wr), .tbl_ptr(tbl_ptr),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_more(eng_more),
        .cmd_q(cmd_q), .active(active), .kick(eng_kick),
        .reload(eng_reload), .cur_ptr(cur_ptr)
    );

    dctl_status u_sts (
        .clk(clk), .rst(rst), .wr(wr), .active(active),
        .drv_irq(drv_irq), .sts_byte(sts_byte), .irq_out(irq_out)
    );

    always_comb begin
        case (reg_sel_e'(rd_sel))
            REG_CMD: rd_raw = {24'd0, cmd_q};
            REG_STS: rd_raw = {24'd0, sts_byte};
            REG_TBL: rd_raw = 32'(tbl_ptr);
            default: rd_raw = '0;
        endcase
        rd_data = lane_pick(acc_size_e'(rd_size), rd_off, rd_raw);
    end

    assign eng_active = active;
    assign eng_dir    = cmd_q[CMD_DIR_BIT];
    assign eng_ptr    = 32'(cur_ptr);

    AST_RELOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
        eng_reload |-> (eng_ptr == $past(32'(tbl_ptr)))); // R3
    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (eng_ptr[1:0] == 2'b00) && (tbl_ptr[1:0] == 2'b00)); // R5
    AST_ACTIVE_MIRROR: assert property (@(posedge clk) disable iff (rst)
        eng_active == sts_byte[STS_ACT_BIT]); // R3

endmodule

// File: tb/test_busdma_ctl_regs.sv
`timescale 1ns/1ps
module test_busdma_ctl_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_en = 1'b0;
    logic [1:0]  acc_sel = '0, acc_off = '0, acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [1:0]  rd_sel = '0, rd_off = '0, rd_size = '0;
    logic [31:0] rd_data;
    logic        eng_busy = 1'b0, eng_done = 1'b0, eng_more = 1'b0;
    logic        eng_kick, eng_reload, eng_active, eng_dir;
    logic [31:0] eng_ptr;
    logic        drv_irq = 1'b0;
    logic        irq_out;

    int nvec = 0;
    int nerr = 0;
    bit finished = 1'b0;

    logic [7:0]  m_cmd;
    logic [31:0] m_ptr, m_cur;
    logic        m_act;

    always #10 clk = ~clk;

    busdma_ctl_regs i_busdma_ctl_regs (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_sel(acc_sel), .acc_off(acc_off),
        .acc_size(acc_size), .acc_wdata(acc_wdata), .rd_sel(rd_sel), .rd_off(rd_off),
        .rd_size(rd_size), .rd_data(rd_data), .eng_busy(eng_busy), .eng_done(eng_done),
        .eng_more(eng_more), .eng_kick(eng_kick), .eng_reload(eng_reload),
        .eng_active(eng_active), .eng_dir(eng_dir), .eng_ptr(eng_ptr),
        .drv_irq(drv_irq), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [1:0] off,
                      input logic [1:0] sz, input logic [31:0] d);
        acc_sel = sel; acc_off = off; acc_size = sz; acc_wdata = d; acc_en = 1'b1;
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [1:0] off,
                      input logic [1:0] sz, output logic [31:0] d);
        rd_sel = sel; rd_off = off; rd_size = sz;
        #1;
        d = rd_data;
    endtask

    function automatic logic [31:0] exp_rd(input logic [31:0] v, input int off, input int sz);
        if (sz == 2) return v;
        if (sz == 0) return (v >> (8*off)) & 32'hFF;
        return (v >> (8*off)) & 32'hFFFF;
    endfunction

    // model of a table pointer write: lanes off..off+n-1 replaced
    function automatic logic [31:0] ptr_model(input logic [31:0] old, input int off,
                                              input int sz, input logic [31:0] d);
        logic [31:0] r = old;
        int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        for (int i = 0; i < n; i++)
            r[8*(off+i) +: 8] = d[8*i +: 8];
        return r & 32'hFFFF_FFFC;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic        prev;
        int          k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), 2'd0, 2'd2, v);
            chk("R10 reg after reset", v, 32'd0);
        end
        chk("R10 outputs after reset", {28'd0, eng_kick, eng_reload, eng_active, eng_dir}, 32'd0);
        chk("R10 eng_ptr after reset", eng_ptr, 32'd0);

        // R5/R9: table pointer lane sweep
        m_ptr = '0;
        k = 0;
        for (int sz = 0; sz < 3; sz++) begin
            for (int off = 0; off < 4; off++) begin
                logic [31:0] d;
                if ((sz == 1 && off == 3) || (sz == 2 && off != 0)) continue;
                k++;
                d = 32'h9E37_79B9 * k;
                if (sz == 0) d = d & 32'hFF;
                if (sz == 1) d = d & 32'hFFFF;
                wr(2'd2, 2'(off), 2'(sz), d);
                m_ptr = ptr_model(m_ptr, off, sz, d);
                for (int rs = 0; rs < 3; rs++) begin
                    for (int ro = 0; ro < 4; ro++) begin
                        if ((rs == 1 && ro == 3) || (rs == 2 && ro != 0)) continue;
                        rd(2'd2, 2'(ro), 2'(rs), v);
                        chk("R5 R9 table pointer lanes", v, exp_rd(m_ptr, ro, rs));
                    end
                end
            end
        end

        // R1/R2/R3/R4: full command byte sweep, engine idle
        m_cmd = '0; m_act = 1'b0; m_cur = '0;
        for (int c = 0; c < 256; c++) begin
            logic exp_rl, exp_kk;
            if ((c % 4) == 0) begin
                wr(2'd2, 2'd0, 2'd2, 32'hC001_0000 + 32'(c * 37));
                m_ptr = ptr_model(m_ptr, 0, 2, 32'hC001_0000 + 32'(c * 37));
            end
            prev = m_cmd[0];
            wr(2'd0, 2'd0, 2'd0, 32'(c));
            exp_rl = c[0] && !prev;
            exp_kk = exp_rl && !m_act;
            if (exp_rl) begin m_act = 1'b1; m_cur = m_ptr; end
            if (!c[0] && prev) m_act = 1'b0;
            m_cmd = 8'(c) & 8'h09;
            chk(exp_rl ? "R3 reload on start rise" : "R2 no reload", {31'd0, eng_reload}, {31'd0, exp_rl});
            chk(exp_kk ? "R3 kick on start rise" : "R2 no kick", {31'd0, eng_kick}, {31'd0, exp_kk});
            chk("R3 R4 active", {31'd0, eng_active}, {31'd0, m_act});
            chk("R3 eng_ptr", eng_ptr, m_cur);
            chk("R1 direction", {31'd0, eng_dir}, {31'd0, m_cmd[3]});
            rd(2'd0, 2'd0, 2'd0, v);
            chk("R1 cmd readback", v, {24'd0, m_cmd});
            rd(2'd1, 2'd0, 2'd0, v);
            chk("R3 status active bit", v & 32'h1, {31'd0, m_act});
        end

        // R2: rewrite start=1 while running with a new pointer: nothing moves
        wr(2'd0, 2'd0, 2'd0, 32'h01);
        wr(2'd2, 2'd0, 2'd2, 32'h0000_4440);
        wr(2'd0, 2'd0, 2'd0, 32'h09);
        chk("R2 repeat start no reload", {31'd0, eng_reload}, 32'd0);
        chk("R2 repeat start ptr kept", eng_ptr, m_ptr);
        chk("R1 direction update", {31'd0, eng_dir}, 32'd1);

        // R4: stop while busy waits for idle
        eng_busy = 1'b1;
        wr(2'd0, 2'd0, 2'd0, 32'h00);
        chk("R4 held during busy", {31'd0, eng_active}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R4 still held", {31'd0, eng_active}, 32'd1);
        eng_busy = 1'b0;
        @(negedge clk);
        chk("R4 cleared after idle", {31'd0, eng_active}, 32'd0);

        // R8: engine completion
        wr(2'd0, 2'd0, 2'd0, 32'h01);
        eng_done = 1'b1; eng_more = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        chk("R8 done with more keeps active", {31'd0, eng_active}, 32'd1);
        eng_done = 1'b1; eng_more = 1'b0;
        @(negedge clk);
        eng_done = 1'b0;
        chk("R8 done without more clears", {31'd0, eng_active}, 32'd0);

        // R7: status write does not touch active, misc bits stored
        wr(2'd1, 2'd0, 2'd0, 32'h61);
        rd(2'd1, 2'd0, 2'd0, v);
        chk("R7 status misc bits, bit0 ignored", v, 32'h60);

        // R6: pass-through and latch
        drv_irq = 1'b1;
        #1;
        chk("R6 irq pass-through high", {31'd0, irq_out}, 32'd1);
        @(negedge clk);
        rd(2'd1, 2'd0, 2'd0, v);
        chk("R6 irq latched", v, 32'h64);
        // R7: W1C clears with level still high (no new edge)
        wr(2'd1, 2'd0, 2'd0, 32'h04);
        rd(2'd1, 2'd0, 2'd0, v);
        chk("R7 irq W1C", v, 32'h00);
        drv_irq = 1'b0;
        #1;
        chk("R6 irq pass-through low", {31'd0, irq_out}, 32'd0);
        @(negedge clk);
        // R7: set wins over a same-cycle clear
        drv_irq = 1'b1;
        wr(2'd1, 2'd0, 2'd0, 32'h04);
        rd(2'd1, 2'd0, 2'd0, v);
        chk("R7 set beats clear", v, 32'h04);
        // R9: select 3 reads zero, offset read of status
        rd(2'd3, 2'd0, 2'd2, v);
        chk("R9 unused select", v, 32'd0);
        rd(2'd1, 2'd1, 2'd0, v);
        chk("R9 status upper lane", v, 32'd0);

        // R10: reset with state present
        wr(2'd0, 2'd0, 2'd0, 32'h09);
        wr(2'd1, 2'd0, 2'd0, 32'h60);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        drv_irq = 1'b0;
        @(negedge clk);
        for (int s = 0; s < 3; s++) begin
            rd(2'(s), 2'd0, 2'd2, v);
            chk("R10 register cleared", v, 32'd0);
        end
        chk("R10 active and ptr cleared", {eng_ptr[30:0], eng_active}, 32'd0);

        finished = 1'b1;
        report();
        $finish;
    end
endmodule